// File: doc/BRIEF.md
# External Bus Request/Grant Controller

This block lets an outside bus master take the processor's external memory bus away from the core through a handshake with an active-low request and an active-low grant. It follows the core's external-access activity through start and done strobes. It hands the bus over only on an access boundary. It then turns off every address, data and strobe driver through one enable and shows the grant.

While the bus is away, the core is either halted outright or, with go mode on, kept running and only held back at its next external access. A hang indicator, also active low, shows when the core or the boot DMA is waiting on a bus it does not own. When the request goes away, the block drops the grant and turns the drivers back on. One cycle later it lets the held access start.

The request/grant path is reset only by the block's own power-on reset. It keeps working while the core is held in reset or is booting, and during that time core access strobes are not counted as activity.

Top module: `busgrant_ctrl`

## Requirements
- R1: The request passes through a 2-flop synchronizer. When it is low while no external access is active, grant goes low in the third cycle after the request was driven low: one cycle after the synchronized request is seen.
- R2: Drivers are disabled (drv_en = 0) in exactly the cycles where grant is low, and the drivers are never enabled while grant is low.
- R3: A request that arrives during an access (between acc_start and acc_done) holds grant high until acc_done. Grant goes low in the cycle after acc_done.
- R4: core_stall is high from the cycle the synchronized request is accepted until one cycle after grant is removed. The bus may be granted between two accesses of one instruction, with the second access held by core_stall.
- R5: With go_mode = 1, core_halt stays low while the bus is granted and core_stall stays high.
- R6: With go_mode = 0, core_halt is high in every cycle that grant is low.
- R7: grant_hang_n is low exactly when grant is low and acc_need is high.
- R8: When the request is released, grant returns high three cycles after it was driven high. In that same cycle drv_en returns high and grant_hang_n is high. core_stall falls one cycle later.
- R9: While core_rst_n is low, acc_start is ignored and no access counts as active. A request is then granted with the R1 latency.
- R10: Under rst_n low, the outputs are grant high, hang high, drv_en high, core_halt low and core_stall low.
- R11: If the request is withdrawn while waiting for an access to end, no grant is given. core_stall falls three cycles after the withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Block power-on reset, asynchronous, active low |
| core_rst_n | input | 1 | Core reset state, low while the core is held in reset |
| bus_req_n | input | 1 | External bus request, asynchronous, active low |
| go_mode | input | 1 | 1: core keeps running while the bus is granted |
| acc_start | input | 1 | Core begins an external access this cycle |
| acc_done | input | 1 | The current external access completes this cycle |
| acc_need | input | 1 | Core or boot DMA has an external access waiting |
| bus_grant_n | output | 1 | Bus grant, active low |
| grant_hang_n | output | 1 | Low while a needed access is blocked by the grant |
| drv_en | output | 1 | Enable for all address, data and strobe drivers |
| core_halt | output | 1 | Halt core execution |
| core_stall | output | 1 | Core must not start a new external access |

## Verification
Directed cases cover a request on an idle bus, a request arriving in the middle of an access, and a grant that falls between the two accesses of one instruction. They also cover go mode with and without a later access need, a request while the core is held in reset, and a request withdrawn before the access ends. Each of these separates a wrong grant cycle from a correct one: too early during an access, one cycle late after done, or a grant given once the request has gone. A long run with random requests, go-mode flips, core resets and a core model that obeys core_stall is compared cycle by cycle against a bench model of the requirements. This run finds ordering faults that the directed cases do not reach, such as an access start and a synchronized request in the same cycle.

// File: rtl/busgrant_pkg.sv
`timescale 1ns/1ps
package busgrant_pkg;
  typedef enum logic [1:0] {
    BG_IDLE     = 2'd0,
    BG_WAIT     = 2'd1,
    BG_OWNED    = 2'd2,
    BG_HANDBACK = 2'd3
  } bg_state_t;
endpackage

// File: rtl/busgrant_sync.sv
`timescale 1ns/1ps
module busgrant_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              chain_en;

  assign chain_en = 1'b1;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = d;
      end else begin : g_next
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (chain_en) begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/busgrant_track.sv
`timescale 1ns/1ps
module busgrant_track (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst_n,
  input  logic acc_start,
  input  logic acc_done,
  output logic active
);
  logic busy_q;
  logic busy_d;
  logic busy_en;

  // An access is active from its start strobe until its done strobe.
  // While the core is in reset, nothing counts as in flight.
  always_comb begin
    busy_en = 1'b1;
    if (core_rst_n) begin
      busy_d = (busy_q | acc_start) & ~acc_done;
    end else begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  assign active = busy_q | (acc_start & core_rst_n);

  assert_core_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |=> !busy_q);
endmodule

// File: rtl/busgrant_fsm.sv
`timescale 1ns/1ps
module busgrant_fsm
  import busgrant_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic active,
  input  logic acc_done,
  input  logic acc_need,
  input  logic go_mode,
  output logic bus_grant_n,
  output logic grant_hang_n,
  output logic drv_en,
  output logic core_halt,
  output logic core_stall
);
  bg_state_t st_q;
  bg_state_t st_d;
  logic      st_en;
  logic      owned;

  always_comb begin
    st_en = 1'b1;
    st_d  = st_q;
    unique case (st_q)
      BG_IDLE: begin
        if (req) begin
          if (active && !acc_done) st_d = BG_WAIT;
          else                     st_d = BG_OWNED;
        end
      end
      BG_WAIT: begin
        if (!req)                     st_d = BG_IDLE;
        else if (!active || acc_done) st_d = BG_OWNED;
      end
      BG_OWNED: begin
        if (!req) st_d = BG_HANDBACK;
      end
      BG_HANDBACK: st_d = BG_IDLE;
      default:     st_d = BG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BG_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  // Grant and driver enable are decoded from one state register,
  // so both change on the same clock edge.
  assign owned        = (st_q == BG_OWNED);
  assign bus_grant_n  = ~owned;
  assign drv_en       = ~owned;
  assign core_halt    = owned & ~go_mode;
  assign core_stall   = (st_q != BG_IDLE);
  assign grant_hang_n = ~(owned & acc_need);

  assert_grant_needs_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> $past(req));
  assert_drivers_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> !drv_en);
  assert_no_grant_mid_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> $past(!active || acc_done));
  assert_stall_while_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> core_stall);
  assert_go_keeps_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && go_mode) |-> !core_halt);
  assert_hang_only_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_hang_n |-> !bus_grant_n);
  assert_handback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant_n) |-> (drv_en && core_stall && grant_hang_n));
endmodule

// File: rtl/busgrant_ctrl.sv
`timescale 1ns/1ps
module busgrant_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst_n,
  input  logic bus_req_n,
  input  logic go_mode,
  input  logic acc_start,
  input  logic acc_done,
  input  logic acc_need,
  output logic bus_grant_n,
  output logic grant_hang_n,
  output logic drv_en,
  output logic core_halt,
  output logic core_stall
);
  logic req_raw;
  logic req_s;
  logic active;

  assign req_raw = ~bus_req_n;

  busgrant_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_raw),
    .q     (req_s)
  );

  busgrant_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n),
    .acc_start  (acc_start),
    .acc_done   (acc_done),
    .active     (active)
  );

  busgrant_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req_s),
    .active       (active),
    .acc_done     (acc_done),
    .acc_need     (acc_need),
    .go_mode      (go_mode),
    .bus_grant_n  (bus_grant_n),
    .grant_hang_n (grant_hang_n),
    .drv_en       (drv_en),
    .core_halt    (core_halt),
    .core_stall   (core_stall)
  );
endmodule

// File: tb/tb_busgrant_ctrl.sv
`timescale 1ns/1ps
module tb_busgrant_ctrl;
  logic clk;
  logic rst_n;
  logic core_rst_n;
  logic bus_req_n;
  logic go_mode;
  logic acc_start;
  logic acc_done;
  logic acc_need;
  logic bus_grant_n;
  logic grant_hang_n;
  logic drv_en;
  logic core_halt;
  logic core_stall;

  int checks = 0;
  int fails  = 0;

  busgrant_ctrl dut (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .bus_req_n(bus_req_n),
    .go_mode(go_mode), .acc_start(acc_start), .acc_done(acc_done),
    .acc_need(acc_need), .bus_grant_n(bus_grant_n), .grant_hang_n(grant_hang_n),
    .drv_en(drv_en), .core_halt(core_halt), .core_stall(core_stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Bench model of the requirements: 2-flop sync, access occupancy, states
  // 0 idle, 1 waiting for access end, 2 granted, 3 handback.
  logic       m_s1, m_s2, m_busy;
  logic [1:0] m_st;
  logic       m_act;
  assign m_act = m_busy | (acc_start & core_rst_n);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_busy <= 1'b0; m_st <= 2'd0;
    end else begin
      m_s1   <= ~bus_req_n;
      m_s2   <= m_s1;
      m_busy <= core_rst_n ? ((m_busy | acc_start) & ~acc_done) : 1'b0;
      case (m_st)
        2'd0: if (m_s2) m_st <= (m_act && !acc_done) ? 2'd1 : 2'd2;
        2'd1: if (!m_s2) m_st <= 2'd0; else if (!m_act || acc_done) m_st <= 2'd2;
        2'd2: if (!m_s2) m_st <= 2'd3;
        default: m_st <= 2'd0;
      endcase
    end
  end

  function automatic logic exp_grant_n(logic [1:0] st);
    return st != 2'd2;
  endfunction
  function automatic logic exp_halt(logic [1:0] st, logic go);
    return (st == 2'd2) && !go;
  endfunction
  function automatic logic exp_stall(logic [1:0] st);
    return st != 2'd0;
  endfunction
  function automatic logic exp_hang_n(logic [1:0] st, logic need);
    return !((st == 2'd2) && need);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2189));
    rst_n = 1'b0; core_rst_n = 1'b1; bus_req_n = 1'b1; go_mode = 1'b0;
    acc_start = 1'b0; acc_done = 1'b0; acc_need = 1'b0;
    step(3);
    // R10 reset state
    check("R10 grant", bus_grant_n, 1'b1);
    check("R10 hang", grant_hang_n, 1'b1);
    check("R10 drv", drv_en, 1'b1);
    check("R10 halt", core_halt, 1'b0);
    check("R10 stall", core_stall, 1'b0);
    rst_n = 1'b1;
    step(2);

    // R1 / R2 / R6 / R7 / R8: request on an idle bus
    bus_req_n = 1'b0;
    step(2);
    check("R1 grant not yet", bus_grant_n, 1'b1);
    step(1);
    check("R1 grant", bus_grant_n, 1'b0);
    check("R2 drv off", drv_en, 1'b0);
    check("R6 halt", core_halt, 1'b1);
    check("R7 hang idle", grant_hang_n, 1'b1);
    acc_need = 1'b1;
    step(1);
    check("R7 hang", grant_hang_n, 1'b0);
    bus_req_n = 1'b1;
    step(2);
    check("R8 still granted", bus_grant_n, 1'b0);
    step(1);
    check("R8 grant off", bus_grant_n, 1'b1);
    check("R8 drv on", drv_en, 1'b1);
    check("R8 hang off", grant_hang_n, 1'b1);
    check("R8 stall held", core_stall, 1'b1);
    check("R8 halt off", core_halt, 1'b0);
    step(1);
    check("R8 stall off", core_stall, 1'b0);
    acc_need = 1'b0;
    step(2);

    // R3 / R4: request mid-access, grant between two accesses
    acc_start = 1'b1; bus_req_n = 1'b0;
    step(1);
    acc_start = 1'b0;
    step(4);
    check("R3 no grant mid access", bus_grant_n, 1'b1);
    check("R4 stall while waiting", core_stall, 1'b1);
    acc_done = 1'b1;
    step(1);
    acc_done = 1'b0; acc_need = 1'b1;
    check("R3 grant after done", bus_grant_n, 1'b0);
    step(1);
    check("R4 second access stalled", core_stall, 1'b1);
    check("R4 hang on second access", grant_hang_n, 1'b0);
    bus_req_n = 1'b1;
    step(3);
    check("R4 grant off", bus_grant_n, 1'b1);
    step(1);
    check("R4 second access free", core_stall, 1'b0);
    acc_need = 1'b0;
    step(2);

    // R5: go mode, no access need then a later need
    go_mode = 1'b1; bus_req_n = 1'b0;
    step(3);
    check("R5 grant", bus_grant_n, 1'b0);
    check("R5 running", core_halt, 1'b0);
    check("R5 stall", core_stall, 1'b1);
    check("R5 no hang", grant_hang_n, 1'b1);
    step(3);
    acc_need = 1'b1;
    step(1);
    check("R5 hang on later need", grant_hang_n, 1'b0);
    check("R5 still running", core_halt, 1'b0);
    bus_req_n = 1'b1; acc_need = 1'b0;
    step(5);
    go_mode = 1'b0;

    // R9: request while the core is held in reset, strobes ignored
    core_rst_n = 1'b0; acc_start = 1'b1; bus_req_n = 1'b0;
    step(3);
    check("R9 grant in core reset", bus_grant_n, 1'b0);
    check("R9 drv off", drv_en, 1'b0);
    bus_req_n = 1'b1;
    step(4);
    acc_start = 1'b0; core_rst_n = 1'b1;
    step(2);

    // R11: request withdrawn while waiting for the access end
    acc_start = 1'b1; bus_req_n = 1'b0;
    step(1);
    acc_start = 1'b0;
    step(3);
    check("R11 waiting", core_stall, 1'b1);
    bus_req_n = 1'b1;
    step(2);
    check("R11 still waiting", core_stall, 1'b1);
    step(1);
    check("R11 back idle", core_stall, 1'b0);
    acc_done = 1'b1;
    step(1);
    acc_done = 1'b0;
    step(1);
    check("R11 no grant", bus_grant_n, 1'b1);
    step(2);

    // Random phase against the bench model
    begin
      logic inflight;
      logic want;
      inflight = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        check("R1 rand grant", bus_grant_n, exp_grant_n(m_st));
        check("R2 rand drv", drv_en, exp_grant_n(m_st));
        check("R6 rand halt", core_halt, exp_halt(m_st, go_mode));
        check("R4 rand stall", core_stall, exp_stall(m_st));
        check("R7 rand hang", grant_hang_n, exp_hang_n(m_st, acc_need));
        if (($urandom % 12) == 0) bus_req_n = ~bus_req_n;
        if (($urandom % 100) == 0) go_mode = ~go_mode;
        if (($urandom % 150) == 0) core_rst_n = ~core_rst_n;
        acc_start = 1'b0; acc_done = 1'b0;
        want = (($urandom % 3) != 0);
        if (!core_rst_n) begin
          inflight = 1'b0;
          acc_start = (($urandom % 2) == 0);
        end else if (inflight) begin
          if (($urandom % 3) == 0) begin
            acc_done = 1'b1;
            inflight = 1'b0;
          end
        end else if (want && !core_stall) begin
          acc_start = 1'b1;
          inflight = 1'b1;
        end
        acc_need = want && core_stall;
      end
    end

    summary();
    $finish;
  end
endmodule